// File: doc/BRIEF.md
# Panel Serial Configuration Sequencer

This block configures a display panel over a three-wire, write-only serial link made of a frame-select line, a serial clock and a data line. One frame is sixteen bits long. The register address takes the upper byte and the register value takes the lower byte, and the most significant bit is sent first. A frame engine produces the pin choreography. The pins idle with select high, clock high and data low. Select falls to open a frame. Each bit is placed on the data line as the clock falls, and the panel captures it on the following rising edge. Select rises again once the sixteenth bit has been clocked.

A start pulse triggers the built-in power-on list. The list holds the panel in reset and standby, releases reset, programs horizontal blanking and input alignment, and finally leaves standby. A single-write port lets a host send one arbitrary register write through the same engine when the block is idle. A parameter sets every serial half-period as a count of system clock cycles.

Top module: `panel_serial_init`

## Requirements
- R1: After a synchronous reset, and whenever `busy` is low, `ser_en`=1, `ser_clk`=1, `ser_dat`=0 and `done`=0.
- R2: Each frame carries exactly 16 bits, MSB first, as {address[7:0], value[7:0]}. The address occupies frame bits 15:8.
- R3: A frame opens when `ser_en` falls while `ser_clk` is high and `ser_dat` is low. `ser_en` then stays low for one half-period before the first clock fall.
- R4: Every bit holds `ser_clk` low for HALF_DIV cycles and then high for HALF_DIV cycles. `ser_dat` changes only in the cycle in which `ser_clk` falls.
- R5: `ser_en` rises HALF_DIV cycles after the sixteenth rising clock edge. Between two frames it stays high for at least 2*HALF_DIV+1 cycles.
- R6: A start sends, in this order, (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F). In register 0x05, bit 6 is the active-low panel reset and bit 0 is the standby control, where 1 means running.
- R7: `busy` rises in the cycle after an accepted start or write and falls after the trailing guard of the last frame. `done` is a one-cycle pulse in the first cycle with `busy` low after the power-on list ends. A single write does not pulse `done`.
- R8: A `start` or `wr_req` sampled while `busy` is high is ignored.
- R9: When idle, `wr_req` sends one frame {`wr_addr`,`wr_val`}. If `start` and `wr_req` arrive together, `start` wins.
- R10: A reset during a frame returns the pins to their idle levels and clears `busy` in the next cycle.
- R11: An accepted request makes `ser_en` fall two cycles after the edge on which the request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the power-on register list |
| wr_req | input | 1 | Requests one single register write |
| wr_addr | input | ADDR_W | Register address of the single write |
| wr_val | input | DATA_W | Register value of the single write |
| ser_en | output | 1 | Frame select, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data |
| busy | output | 1 | A frame or the power-on list is in progress |
| done | output | 1 | One-cycle pulse at the end of the power-on list |

## Verification
The assertions rely on reset being asserted for at least one edge before the first request. They also rely on reset only ever forcing the pins to idle, so every select edge they see comes from the frame engine. The stimulus applies reset first and drives `start`, `wr_req` and the write fields half a cycle away from the sampling edge. Requests that overlap an active transfer are issued on purpose, including simultaneous start and write, so that the rules for ignored requests are exercised. The reset in the middle of a frame is applied only while the bench model is also reset, so the pin checks stay valid across it.

// File: rtl/panel_ser_pkg.sv
package panel_ser_pkg;

   // number of entries in the power-on list
   localparam int INIT_STEPS = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPEN,
      PH_LOW,
      PH_HIGH,
      PH_CLOSE
   } ser_phase_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SEND,
      SQ_WAIT
   } seq_state_e;

   // power-on list: {address, value}; order matters (reset, release, timing, mode, wake)
   function automatic logic [15:0] init_entry(input int idx);
      logic [15:0] e;
      case (idx)
         0:       e = 16'h051E;
         1:       e = 16'h055E;
         2:       e = 16'h078D;
         3:       e = 16'h1301;
         default: e = 16'h055F;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/panel_phase_timer.sv
module panel_phase_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic long_sel,
   output logic expire
);

   generate
      if (HALF_DIV == 1) begin : g_unit
         // short phases last one cycle; only the long phase needs a second cycle
         logic extra_q;
         always_ff @(posedge clk) begin
            if (rst)       extra_q <= 1'b0;
            else if (load) extra_q <= long_sel;
            else           extra_q <= 1'b0;
         end
         assign expire = !extra_q;
      end else begin : g_count
         localparam int CW = $clog2(2 * HALF_DIV);
         localparam logic [CW-1:0] SHORT_LD = CW'(HALF_DIV - 1);
         localparam logic [CW-1:0] LONG_LD  = CW'(2 * HALF_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (load)          cnt_q <= long_sel ? LONG_LD : SHORT_LD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign expire = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/panel_frame_tx.sv
module panel_frame_tx
   import panel_ser_pkg::*;
#(
   parameter int FRAME_W  = 16,
   parameter int HALF_DIV = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               go,
   input  logic [FRAME_W-1:0] frame,
   output logic               fin,
   output logic               ser_en,
   output logic               ser_clk,
   output logic               ser_dat
);

   localparam int BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   if (FRAME_W < 2) begin : g_bad_width
      $error("panel_frame_tx: FRAME_W must be at least 2");
   end

   ser_phase_e         phase_q, nxt_phase;
   logic [FRAME_W-1:0] sh_q, nxt_sh;
   logic [BW-1:0]      bit_q, nxt_bit;
   logic               tick, load, long_sel;

   panel_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .long_sel (long_sel),
      .expire   (tick)
   );

   always_comb begin
      nxt_phase = phase_q;
      nxt_sh    = sh_q;
      nxt_bit   = bit_q;
      load      = 1'b0;
      fin       = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (go) begin
            nxt_phase = PH_OPEN;
            nxt_sh    = frame;
            nxt_bit   = '0;
            load      = 1'b1;
         end
         PH_OPEN: if (tick) begin
            nxt_phase = PH_LOW;
            load      = 1'b1;
         end
         PH_LOW: if (tick) begin
            nxt_phase = PH_HIGH;
            load      = 1'b1;
         end
         PH_HIGH: if (tick) begin
            load = 1'b1;
            if (bit_q == LAST_BIT) begin
               nxt_phase = PH_CLOSE;
            end else begin
               nxt_phase = PH_LOW;
               nxt_sh    = {sh_q[FRAME_W-2:0], 1'b0};
               nxt_bit   = bit_q + 1'b1;
            end
         end
         PH_CLOSE: if (tick) begin
            nxt_phase = PH_IDLE;
            fin       = 1'b1;
         end
         default: nxt_phase = PH_IDLE;
      endcase
      long_sel = (nxt_phase == PH_CLOSE);
   end

   // pins come straight from flops, decoded from the next phase
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         sh_q    <= '0;
         bit_q   <= '0;
         ser_en  <= 1'b1;
         ser_clk <= 1'b1;
         ser_dat <= 1'b0;
      end else begin
         phase_q <= nxt_phase;
         sh_q    <= nxt_sh;
         bit_q   <= nxt_bit;
         ser_en  <= (nxt_phase == PH_IDLE) || (nxt_phase == PH_CLOSE);
         ser_clk <= (nxt_phase != PH_LOW);
         ser_dat <= ((nxt_phase == PH_LOW) || (nxt_phase == PH_HIGH)) && nxt_sh[FRAME_W-1];
      end
   end

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_ser_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int STEPS  = INIT_STEPS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     wr_req,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_val,
   input  logic                     tx_fin,
   output logic                     tx_go,
   output logic [ADDR_W+DATA_W-1:0] tx_frame,
   output logic                     busy,
   output logic                     done
);

   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int IW      = $clog2(STEPS);
   localparam logic [IW-1:0] LAST_IDX = IW'(STEPS - 1);

   if (STEPS < 2) begin : g_bad_steps
      $error("panel_init_seq: STEPS must be at least 2");
   end

   logic [FRAME_W-1:0] rom [STEPS];

   for (genvar g = 0; g < STEPS; g++) begin : g_rom
      localparam logic [15:0] ENTRY = init_entry(g);
      assign rom[g] = {ADDR_W'(ENTRY[15:8]), DATA_W'(ENTRY[7:0])};
   end

   seq_state_e         state_q;
   logic [IW-1:0]      idx_q;
   logic               seq_mode_q;
   logic [FRAME_W-1:0] hold_q;
   logic               done_q;

   assign tx_go    = (state_q == SQ_SEND);
   assign tx_frame = seq_mode_q ? rom[idx_q] : hold_q;
   assign busy     = (state_q != SQ_IDLE);
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= SQ_IDLE;
         idx_q      <= '0;
         seq_mode_q <= 1'b0;
         hold_q     <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  idx_q      <= '0;
                  seq_mode_q <= 1'b1;
                  state_q    <= SQ_SEND;
               end else if (wr_req) begin
                  seq_mode_q <= 1'b0;
                  hold_q     <= {wr_addr, wr_val};
                  state_q    <= SQ_SEND;
               end
            end
            SQ_SEND: state_q <= SQ_WAIT;
            SQ_WAIT: if (tx_fin) begin
               if (seq_mode_q && (idx_q != LAST_IDX)) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= SQ_SEND;
               end else begin
                  state_q <= SQ_IDLE;
                  done_q  <= seq_mode_q;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/panel_serial_init.sv
module panel_serial_init
   import panel_ser_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int HALF_DIV = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_val,
   output logic              ser_en,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              busy,
   output logic              done
);

   localparam int FRAME_W = ADDR_W + DATA_W;

   if (ADDR_W < 8 || DATA_W < 8) begin : g_bad_fields
      $error("panel_serial_init: ADDR_W and DATA_W must hold the 8-bit power-on entries");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("panel_serial_init: HALF_DIV must be at least 1");
   end

   logic               tx_go, tx_fin;
   logic [FRAME_W-1:0] tx_frame;

   panel_init_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STEPS  (INIT_STEPS)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .wr_req   (wr_req),
      .wr_addr  (wr_addr),
      .wr_val   (wr_val),
      .tx_fin   (tx_fin),
      .tx_go    (tx_go),
      .tx_frame (tx_frame),
      .busy     (busy),
      .done     (done)
   );

   panel_frame_tx #(
      .FRAME_W  (FRAME_W),
      .HALF_DIV (HALF_DIV)
   ) u_tx (
      .clk     (clk),
      .rst     (rst),
      .go      (tx_go),
      .frame   (tx_frame),
      .fin     (tx_fin),
      .ser_en  (ser_en),
      .ser_clk (ser_clk),
      .ser_dat (ser_dat)
   );

endmodule

// File: rtl/panel_serial_init_checker.sv
module panel_serial_init_checker #(
   parameter int HALF_DIV = 4
) (
   input logic clk,
   input logic rst,
   input logic ser_en,
   input logic ser_clk,
   input logic ser_dat,
   input logic busy,
   input logic done
);

   localparam logic [31:0] MIN_GAP = 32'(2 * HALF_DIV + 1);

   // cycles the select line has been high, saturating; starts saturated after reset
   logic [31:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst)                  gap_q <= '1;
      else if (!ser_en)         gap_q <= '0;
      else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
   end

   a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (ser_en && ser_clk && !ser_dat && !done) || (done && ser_en && ser_clk && !ser_dat));

   a_r1_clk_only_in_frame: assert property (@(posedge clk) disable iff (rst)
      !ser_clk |-> !ser_en);

   a_r3_open_levels: assert property (@(posedge clk) disable iff (rst)
      $fell(ser_en) |-> ser_clk && !ser_dat);

   a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
      (!ser_en && $past(!ser_en) && ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

   a_r5_close_clk_high: assert property (@(posedge clk) disable iff (rst)
      $rose(ser_en) |-> ser_clk && $past(ser_clk));

   a_r5_min_gap: assert property (@(posedge clk) disable iff (rst)
      $fell(ser_en) |-> gap_q >= MIN_GAP);

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy && $past(busy));

endmodule

bind panel_serial_init panel_serial_init_checker #(.HALF_DIV(HALF_DIV)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ser_en  (ser_en),
   .ser_clk (ser_clk),
   .ser_dat (ser_dat),
   .busy    (busy),
   .done    (done)
);

// File: tb/panel_serial_init_bench.sv
module panel_serial_init_bench;

   localparam int H = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       wr_req = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_val = '0;
   logic       ser_en, ser_clk, ser_dat, busy, done;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   panel_serial_init #(.ADDR_W(8), .DATA_W(8), .HALF_DIV(H)) u_panel_serial_init (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .wr_req  (wr_req),
      .wr_addr (wr_addr),
      .wr_val  (wr_val),
      .ser_en  (ser_en),
      .ser_clk (ser_clk),
      .ser_dat (ser_dat),
      .busy    (busy),
      .done    (done)
   );

   // ---------------- reference model ----------------
   function automatic logic [15:0] power_on_word(input int i);
      logic [15:0] w;
      case (i)
         0: w = {8'h05, 8'h1E};
         1: w = {8'h05, 8'h5E};
         2: w = {8'h07, 8'h8D};
         3: w = {8'h13, 8'h01};
         default: w = {8'h05, 8'h5F};
      endcase
      return w;
   endfunction

   logic [2:0] wave[$];        // {en, clk, dat} per cycle
   logic m_en = 1'b1, m_clk = 1'b1, m_dat = 1'b0, m_busy = 1'b0, m_done = 1'b0;
   logic seq_mode = 1'b0, pend_done = 1'b0;

   task automatic push_frame(input logic [15:0] w);
      wave.push_back(3'b110);
      for (int k = 0; k < H; k++) wave.push_back(3'b010);
      for (int b = 15; b >= 0; b--) begin
         for (int k = 0; k < H; k++) wave.push_back({2'b00, w[b]});
         for (int k = 0; k < H; k++) wave.push_back({2'b01, w[b]});
      end
      for (int k = 0; k < 2 * H; k++) wave.push_back(3'b110);
   endtask

   always @(posedge clk) begin
      if (rst) begin
         wave.delete();
         {m_en, m_clk, m_dat} = 3'b110;
         m_busy = 1'b0; m_done = 1'b0; pend_done = 1'b0; seq_mode = 1'b0;
      end else begin
         if (!m_busy) begin
            if (start) begin
               for (int i = 0; i < 5; i++) push_frame(power_on_word(i));
               seq_mode = 1'b1;
            end else if (wr_req) begin
               push_frame({wr_addr, wr_val});
               seq_mode = 1'b0;
            end
         end
         if (wave.size() > 0) begin
            {m_en, m_clk, m_dat} = wave.pop_front();
            m_busy = 1'b1; m_done = 1'b0;
            pend_done = (wave.size() == 0) && seq_mode;
         end else begin
            {m_en, m_clk, m_dat} = 3'b110;
            m_busy = 1'b0; m_done = pend_done; pend_done = 1'b0;
         end
      end
   end

   // ---------------- per-cycle comparison and frame capture ----------------
   logic [15:0] cap_w[$];
   int          cap_n[$];
   logic [15:0] cur_w = '0;
   int          cur_n = 0;
   int          done_cnt = 0;
   logic        p_en = 1'b1, p_clk = 1'b1;

   always @(negedge clk) begin
      cycles++;
      if (!rst) begin
         tests++;
         if ({ser_en, ser_clk, ser_dat} !== {m_en, m_clk, m_dat}) begin
            fails++;
            $display("FAIL R3,R4,R5,R11 pins cycle %0d: actual en/clk/dat=%b expected=%b",
                     cycles, {ser_en, ser_clk, ser_dat}, {m_en, m_clk, m_dat});
         end
         tests++;
         if ({busy, done} !== {m_busy, m_done}) begin
            fails++;
            $display("FAIL R7 busy/done cycle %0d: actual=%b expected=%b",
                     cycles, {busy, done}, {m_busy, m_done});
         end
         if (done) done_cnt++;
         if (!ser_en && p_en) begin cur_n = 0; cur_w = '0; end
         if (!ser_en && !p_clk && ser_clk) begin cur_w = {cur_w[14:0], ser_dat}; cur_n++; end
         if (ser_en && !p_en) begin cap_w.push_back(cur_w); cap_n.push_back(cur_n); end
      end
      p_en = ser_en; p_clk = ser_clk;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string msg, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   task automatic settle();
      for (int n = 0; n < 3000 && (m_busy || m_done || busy); n++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_capture();
      cap_w.delete(); cap_n.delete(); done_cnt = 0;
   endtask

   task automatic check_words(input logic [15:0] exp[$], input string tag);
      check(cap_w.size() == exp.size(), {tag, " frame count"}, cap_w.size(), exp.size());
      for (int i = 0; i < exp.size() && i < cap_w.size(); i++) begin
         check(cap_w[i] == exp[i], {tag, " frame word"}, cap_w[i], exp[i]);
         check(cap_n[i] == 16, "R2 bits per frame", cap_n[i], 16);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] exp[$];
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset levels
      check({ser_en, ser_clk, ser_dat, busy, done} == 5'b11000, "R1 idle levels",
            {ser_en, ser_clk, ser_dat, busy, done}, 5'b11000);

      // R6 power-on list, with a repeated start while busy (R8)
      clear_capture();
      start = 1'b1; @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      settle();
      exp = {};
      for (int i = 0; i < 5; i++) exp.push_back(power_on_word(i));
      check_words(exp, "R6");
      check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
      check(cap_w.size() == 5, "R8 start while busy ignored", cap_w.size(), 5);

      // R9 single write, with a second write while busy (R8)
      clear_capture();
      wr_addr = 8'hA5; wr_val = 8'h3C; wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0;
      repeat (20) @(negedge clk);
      wr_addr = 8'hFF; wr_val = 8'hFF; wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0;
      settle();
      exp = {16'hA53C};
      check_words(exp, "R9 single");
      check(done_cnt == 0, "R7 no done for single write", done_cnt, 0);

      // R9 priority: start and write together
      clear_capture();
      wr_addr = 8'h42; wr_val = 8'h24; wr_req = 1'b1; start = 1'b1;
      @(negedge clk); wr_req = 1'b0; start = 1'b0;
      settle();
      exp = {};
      for (int i = 0; i < 5; i++) exp.push_back(power_on_word(i));
      check_words(exp, "R9 priority");

      // R10 reset in the middle of a frame
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check({ser_en, ser_clk, ser_dat, busy} == 4'b1100, "R10 idle after reset",
            {ser_en, ser_clk, ser_dat, busy}, 4'b1100);
      repeat (5) @(negedge clk);
      check(busy == 1'b0, "R10 stays idle", busy, 0);

      // R2 alternate bit patterns after reset
      clear_capture();
      wr_addr = 8'h80; wr_val = 8'h01; wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0;
      settle();
      wr_addr = 8'h5A; wr_val = 8'hC3; wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0;
      settle();
      exp = {16'h8001, 16'h5AC3};
      check_words(exp, "R2 patterns");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule